// File: doc/BRIEF.md
# Powerdown and Calibration Sequencer

This block turns one active-high control line into the power-down and self-calibration sequence of a clock-recovery loop. While the line is high, the loop is held powered down and the recovered clock and data outputs are parked at a fixed idle level. When the line falls after a long enough high period, the block runs reset, calibration and acquisition in that order, and it ends in a tracking state. The block also masks the loss-of-lock alarm whenever that alarm means nothing.

The level of the control line means power-down and its falling edge means calibrate. The line first passes through a synchroniser. A falling edge counts as a calibration request only if the synchronised line was high for at least `MIN_HIGH_CYC` clock edges. A shorter pulse only takes the block out of power-down. The block then resets and parks in an uncalibrated idle state until the next power-down. Calibration also needs a valid reference clock, so the block waits for `ref_valid` before it raises the calibration enable. The calibration engine is external and reports back with a one-cycle `cal_done`.

The states are PWRDN, RESET, IDLE, REFWAIT, CAL, ACQ and TRACK. The transitions are as follows. A high synchronised line moves any state to PWRDN. PWRDN moves to RESET on a falling edge. RESET moves to REFWAIT after `RST_CYC` cycles if the edge was qualified, and to IDLE if it was not. REFWAIT moves to CAL when `ref_valid` is high. CAL moves to ACQ on `cal_done`. ACQ moves to TRACK once `ACQ_CYC` cycles have passed since the falling edge was seen.

Top module: `pdcal_seq`

## Requirements
- R1: Within 3 clock edges of `pd_cal_in` going high, `loop_pd` is 1 and `rclk_out` and every bit of `rdata_out` equal `IDLE_LVL` (default 1). Outside power-down, `rclk_out` and `rdata_out` pass `rclk_in` and `rdata_in` through.
- R2: `cal_en` is never 1 while the synchronised control line is high. Calibration starts only after a high-to-low transition.
- R3: A falling edge is a calibration request only if `pd_cal_in` was high for at least `MIN_HIGH_CYC` consecutive clock edges. With one edge fewer, no calibration follows.
- R4: After an unqualified falling edge, the block goes through RESET into IDLE. There `loop_pd`, `cal_en` and `ready` stay 0 and the data path passes through until the next power-down.
- R5: Every release from power-down gives a `rst_strobe` pulse of exactly `RST_CYC` cycles. The pulse starts in the cycle after `loop_pd` falls and comes before any `cal_en`.
- R6: `cal_en` rises only after a cycle in which `ref_valid` was sampled high. With the control line driven low before clock edge 1, `cal_en` is first seen after edge max(`RST_CYC`+4, k+1), where `ref_valid` is raised after edge k.
- R7: `cal_en` stays high until `cal_done` is sampled and drops on the next edge. With a `cal_done` latency of L cycles, `cal_en` is high for exactly L cycles.
- R8: `ready` rises after edge max(`ACQ_CYC`+3, c+L+1), where c is the first edge with `cal_en` high. `acq_busy` is high in the cycle just before `ready` rises.
- R9: `lol_out` equals `lol_raw` except in PWRDN, RESET, REFWAIT and CAL, where it is 0.
- R10: At most one of `loop_pd`, `rst_strobe`, `cal_en`, `acq_busy` and `ready` is high at a time. `ready` is high only in TRACK.
- R11: A high control line aborts any state, including CAL and TRACK, and returns the block to power-down within 3 edges.
- R12: While `rst_n` is low, the block is in PWRDN: `loop_pd` is 1, `ready` is 0 and `rst_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_cal_in | input | 1 | Control line: high means power-down, a qualified falling edge means calibrate |
| ref_valid | input | 1 | Reference clock detected as active |
| cal_done | input | 1 | One-cycle completion pulse from the calibration engine |
| lol_raw | input | 1 | Unmasked loss-of-lock indication from the lock detector |
| rclk_in | input | 1 | Recovered clock from the loop |
| rdata_in | input | DATA_W | Recovered data from the loop |
| loop_pd | output | 1 | Holds the loop powered down |
| rst_strobe | output | 1 | Loop control reset, high for RST_CYC cycles |
| cal_en | output | 1 | Calibration enable |
| acq_busy | output | 1 | Acquisition in progress |
| lol_mask | output | 1 | Loss-of-lock alarm suppressed |
| lol_out | output | 1 | Masked loss-of-lock alarm |
| ready | output | 1 | Loop calibrated and tracking |
| rclk_out | output | 1 | Recovered clock, or the idle level in power-down |
| rdata_out | output | DATA_W | Recovered data, or the idle level in power-down |

## Verification
The one-hot status outputs show the state directly, so a wrong next-state decision appears on the ports in the cycle after the edge that made it. A wrong high-time count has a different signature: the block either calibrates after a short pulse or parks in IDLE after a long one, and this is visible from the seventh edge after the fall. A miscounted acquisition timer shifts the rise of `ready` by the error, and the bench checks that rise against an exact edge. A missing mask appears as `lol_out` high during power-down or calibration while `lol_raw` is held high.

// File: rtl/pdcal_pkg.sv
`timescale 1ns/1ps
package pdcal_pkg;

    typedef enum logic [2:0] {
        ST_PWRDN   = 3'd0,
        ST_RESET   = 3'd1,
        ST_IDLE    = 3'd2,
        ST_REFWAIT = 3'd3,
        ST_CAL     = 3'd4,
        ST_ACQ     = 3'd5,
        ST_TRACK   = 3'd6
    } seq_state_t;

endpackage

// File: rtl/pdcal_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for a single asynchronous level.
module pdcal_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic ff;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff <= RST_VAL;
                else        ff <= d;
            end
            assign q = ff;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= {STAGES{RST_VAL}};
                else        sh <= {sh[STAGES-2:0], d};
            end
            assign q = sh[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pdcal_qual.sv
`timescale 1ns/1ps
// Falling-edge detector with a saturating high-time qualifier.
module pdcal_qual #(
    parameter int MIN_HIGH_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,        // synchronised control level
    output logic fall,       // high-to-low seen this cycle
    output logic qualified   // fall preceded by a long enough high time
);

    localparam int CW = $clog2(MIN_HIGH_CYC + 1);
    localparam logic [CW-1:0] HI_MAX = CW'(MIN_HIGH_CYC);

    logic          lvl_d;
    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_d  <= 1'b1;
            hi_cnt <= '0;
        end else begin
            lvl_d <= lvl;
            if (lvl) begin
                if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
            end
        end
    end

    assign fall      = lvl_d & ~lvl;
    assign qualified = fall & (hi_cnt == HI_MAX);

endmodule

// File: rtl/pdcal_acq_timer.sv
`timescale 1ns/1ps
// Counts cycles from the qualified falling edge; saturates when expired.
module pdcal_acq_timer #(
    parameter int ACQ_CYC = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic expired
);

    localparam int TW = $clog2(ACQ_CYC + 1);
    localparam logic [TW-1:0] T_MAX = TW'(ACQ_CYC);

    logic [TW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (clear) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= TW'(1);
            run <= 1'b1;
        end else if (run && (cnt != T_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run & (cnt == T_MAX);

endmodule

// File: rtl/pdcal_seq.sv
`timescale 1ns/1ps
// Power-down / self-calibration sequencer for a clock-recovery loop.
module pdcal_seq
    import pdcal_pkg::*;
#(
    parameter int   DATA_W       = 8,
    parameter int   SYNC_STAGES  = 2,
    parameter int   MIN_HIGH_CYC = 100,
    parameter int   RST_CYC      = 4,
    parameter int   ACQ_CYC      = 150000,
    parameter logic IDLE_LVL     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_cal_in,
    input  logic              ref_valid,
    input  logic              cal_done,
    input  logic              lol_raw,
    input  logic              rclk_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              loop_pd,
    output logic              rst_strobe,
    output logic              cal_en,
    output logic              acq_busy,
    output logic              lol_mask,
    output logic              lol_out,
    output logic              ready,
    output logic              rclk_out,
    output logic [DATA_W-1:0] rdata_out
);

    localparam int RCW = $clog2(RST_CYC + 1);
    localparam logic [RCW-1:0] RST_LAST = RCW'(RST_CYC - 1);

    seq_state_t     state, nxt;
    logic           pd_lvl;
    logic           fall;
    logic           qualified;
    logic           acq_expired;
    logic           cal_req;
    logic [RCW-1:0] rcnt;
    logic           rst_last;
    logic           timer_start;

    pdcal_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pd_cal_in),
        .q     (pd_lvl)
    );

    pdcal_qual #(
        .MIN_HIGH_CYC (MIN_HIGH_CYC)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (pd_lvl),
        .fall      (fall),
        .qualified (qualified)
    );

    assign timer_start = qualified && (state == ST_PWRDN);

    pdcal_acq_timer #(
        .ACQ_CYC (ACQ_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pd_lvl),
        .start   (timer_start),
        .expired (acq_expired)
    );

    // Reset-phase counter and latched calibration request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt    <= '0;
            cal_req <= 1'b0;
        end else begin
            if (state == ST_RESET) rcnt <= rcnt + 1'b1;
            else                   rcnt <= '0;
            if (pd_lvl)                             cal_req <= 1'b0;
            else if ((state == ST_PWRDN) && fall)   cal_req <= qualified;
        end
    end

    assign rst_last = (rcnt == RST_LAST);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWRDN;
        else        state <= nxt;
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        if (pd_lvl) begin
            nxt = ST_PWRDN;
        end else begin
            unique case (state)
                ST_PWRDN:   if (fall)        nxt = ST_RESET;
                ST_RESET:   if (rst_last)    nxt = cal_req ? ST_REFWAIT : ST_IDLE;
                ST_IDLE:                     nxt = ST_IDLE;
                ST_REFWAIT: if (ref_valid)   nxt = ST_CAL;
                ST_CAL:     if (cal_done)    nxt = ST_ACQ;
                ST_ACQ:     if (acq_expired) nxt = ST_TRACK;
                ST_TRACK:                    nxt = ST_TRACK;
                default:                     nxt = ST_PWRDN;
            endcase
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        loop_pd    = 1'b0;
        rst_strobe = 1'b0;
        cal_en     = 1'b0;
        acq_busy   = 1'b0;
        ready      = 1'b0;
        lol_mask   = 1'b0;
        unique case (state)
            ST_PWRDN:   begin loop_pd    = 1'b1; lol_mask = 1'b1; end
            ST_RESET:   begin rst_strobe = 1'b1; lol_mask = 1'b1; end
            ST_IDLE:    begin end
            ST_REFWAIT: begin lol_mask   = 1'b1; end
            ST_CAL:     begin cal_en     = 1'b1; lol_mask = 1'b1; end
            ST_ACQ:     begin acq_busy   = 1'b1; end
            ST_TRACK:   begin ready      = 1'b1; end
            default:    begin loop_pd    = 1'b1; lol_mask = 1'b1; end
        endcase
        lol_out   = lol_raw & ~lol_mask;
        rclk_out  = loop_pd ? IDLE_LVL : rclk_in;
        rdata_out = loop_pd ? {DATA_W{IDLE_LVL}} : rdata_in;
    end

endmodule

// File: rtl/pdcal_seq_chk.sv
`timescale 1ns/1ps
module pdcal_seq_chk #(
    parameter logic IDLE_LVL = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic ref_valid,
    input logic cal_done,
    input logic loop_pd,
    input logic rst_strobe,
    input logic cal_en,
    input logic acq_busy,
    input logic lol_out,
    input logic ready,
    input logic rclk_out
);

    AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        loop_pd |-> (rclk_out == IDLE_LVL)); // R1

    AST_RELEASE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loop_pd) |-> rst_strobe); // R5

    AST_CAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_en) |-> ($past(ref_valid) && !$past(loop_pd))); // R6

    AST_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_en && !cal_done) |=> (cal_en || loop_pd)); // R7

    AST_CAL_END: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_en && cal_done) |=> !cal_en); // R7

    AST_TRACK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(acq_busy)); // R8

    AST_LOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_pd || cal_en) |-> !lol_out); // R9

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loop_pd, rst_strobe, cal_en, acq_busy, ready})); // R10

endmodule

bind pdcal_seq pdcal_seq_chk #(.IDLE_LVL(IDLE_LVL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_valid  (ref_valid),
    .cal_done   (cal_done),
    .loop_pd    (loop_pd),
    .rst_strobe (rst_strobe),
    .cal_en     (cal_en),
    .acq_busy   (acq_busy),
    .lol_out    (lol_out),
    .ready      (ready),
    .rclk_out   (rclk_out)
);

// File: tb/pdcal_seq_tb.sv
`timescale 1ns/1ps
module pdcal_seq_tb;

    localparam int DW     = 8;
    localparam int MINH   = 20;
    localparam int RSTC   = 4;
    localparam int ACQC   = 300;
    localparam int RUNLEN = 420;
    localparam logic [DW-1:0] PASS_DATA = 8'h5A;

    // hi_len, ref_dly (0 = valid from the start), cal latency
    localparam int TBL [7][3] = '{
        '{20,   0,   3},
        '{19,   0,   3},
        '{60,  40,  10},
        '{5,    0,   3},
        '{25, 350,   6},
        '{21,   8,   1},
        '{30,   7, 294}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pd_cal_in = 1'b1;
    logic          ref_valid = 1'b0;
    logic          cal_done = 1'b0;
    logic          lol_raw = 1'b1;
    logic          rclk_in = 1'b0;
    logic [DW-1:0] rdata_in = PASS_DATA;
    logic          loop_pd, rst_strobe, cal_en, acq_busy, lol_mask, lol_out, ready, rclk_out;
    logic [DW-1:0] rdata_out;

    int total = 0;
    int bad = 0;
    int cal_lat = 3;
    int cal_cnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pdcal_seq #(
        .DATA_W       (DW),
        .SYNC_STAGES  (2),
        .MIN_HIGH_CYC (MINH),
        .RST_CYC      (RSTC),
        .ACQ_CYC      (ACQC),
        .IDLE_LVL     (1'b1)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_cal_in  (pd_cal_in),
        .ref_valid  (ref_valid),
        .cal_done   (cal_done),
        .lol_raw    (lol_raw),
        .rclk_in    (rclk_in),
        .rdata_in   (rdata_in),
        .loop_pd    (loop_pd),
        .rst_strobe (rst_strobe),
        .cal_en     (cal_en),
        .acq_busy   (acq_busy),
        .lol_mask   (lol_mask),
        .lol_out    (lol_out),
        .ready      (ready),
        .rclk_out   (rclk_out),
        .rdata_out  (rdata_out)
    );

    // Calibration engine stub: done pulse after cal_lat cycles of cal_en.
    always @(negedge clk) begin
        if (cal_en) begin
            cal_cnt = cal_cnt + 1;
            cal_done = (cal_cnt == cal_lat);
        end else begin
            cal_cnt = 0;
            cal_done = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_idle_outputs(input string tag);
        chk(loop_pd == 1'b1, {tag, " R1 loop_pd"}, int'(loop_pd), 1);
        chk(rclk_out == 1'b1 && rdata_out == '1, {tag, " R1 idle level"}, int'(rdata_out), 255);
        chk(lol_out == 1'b0, {tag, " R9 lol masked in power-down"}, int'(lol_out), 0);
        chk(cal_en == 1'b0, {tag, " R2 no cal while high"}, int'(cal_en), 0);
    endtask

    task automatic run_entry(input int hi_len, input int ref_dly, input int lat);
        bit qual;
        int exp_cal, exp_rdy, first_cal, first_rdy, rst_cnt, cal_n, lol_bad;
        bit acq_prev, rdy_after_acq;
        qual = (hi_len >= MINH);
        cal_lat = lat;
        ref_valid = (ref_dly == 0);
        pd_cal_in = 1'b1;
        for (int k = 0; k < hi_len; k++) begin
            tick();
            if (k == 2 || k == hi_len - 1) check_idle_outputs("high");
        end
        pd_cal_in = 1'b0;
        first_cal = -1; first_rdy = -1; rst_cnt = 0; cal_n = 0; lol_bad = 0;
        acq_prev = 1'b0; rdy_after_acq = 1'b0;
        for (int i = 1; i <= RUNLEN; i++) begin
            tick();
            if (rst_strobe) rst_cnt++;
            if (cal_en) begin
                cal_n++;
                if (first_cal < 0) first_cal = i;
                if (lol_out) lol_bad++;
            end
            if (ready && first_rdy < 0) begin
                first_rdy = i;
                rdy_after_acq = acq_prev;
            end
            acq_prev = acq_busy;
            if (i == ref_dly) ref_valid = 1'b1;
        end
        chk(rst_cnt == RSTC, "R5 reset strobe length", rst_cnt, RSTC);
        if (qual) begin
            exp_cal = (RSTC + 4 > ref_dly + 1) ? RSTC + 4 : ref_dly + 1;
            exp_rdy = (ACQC + 3 > exp_cal + lat + 1) ? ACQC + 3 : exp_cal + lat + 1;
            chk(first_cal == exp_cal, "R3 R6 calibration start edge", first_cal, exp_cal);
            chk(cal_n == lat, "R7 cal_en length", cal_n, lat);
            chk(lol_bad == 0, "R9 lol masked during cal", lol_bad, 0);
            chk(first_rdy == exp_rdy, "R8 ready edge", first_rdy, exp_rdy);
            chk(rdy_after_acq, "R8 acq_busy before ready", int'(rdy_after_acq), 1);
            chk(ready && !acq_busy && !cal_en && !loop_pd, "R10 ready alone", int'(ready), 1);
            chk(lol_out == lol_raw, "R9 lol passes in track", int'(lol_out), int'(lol_raw));
            chk(rdata_out == PASS_DATA && rclk_out == rclk_in, "R1 pass-through", int'(rdata_out), int'(PASS_DATA));
        end else begin
            chk(cal_n == 0, "R3 short pulse gives no cal", cal_n, 0);
            chk(first_rdy == -1, "R4 no ready in idle", first_rdy, -1);
            chk(loop_pd == 1'b0 && rdata_out == PASS_DATA && rclk_out == rclk_in,
                "R4 idle passes data", int'(rdata_out), int'(PASS_DATA));
            chk(lol_out == lol_raw, "R9 lol passes in idle", int'(lol_out), int'(lol_raw));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) tick();
        chk(loop_pd == 1'b1 && ready == 1'b0 && rst_strobe == 1'b0, "R12 reset state", int'(loop_pd), 1);
        chk(rdata_out == '1, "R12 R1 idle data in reset", int'(rdata_out), 255);
        rst_n = 1'b1;
        repeat (3) tick();
        check_idle_outputs("post-reset");

        // Vector table walk
        for (int e = 0; e < 7; e++) run_entry(TBL[e][0], TBL[e][1], TBL[e][2]);

        // R11: abort during calibration
        cal_lat = 1000;
        ref_valid = 1'b1;
        pd_cal_in = 1'b1;
        repeat (25) tick();
        pd_cal_in = 1'b0;
        for (int i = 0; i < 20 && !cal_en; i++) tick();
        chk(cal_en == 1'b1, "R11 reached calibration", int'(cal_en), 1);
        pd_cal_in = 1'b1;
        repeat (3) tick();
        chk(loop_pd == 1'b1 && cal_en == 1'b0, "R11 abort from cal", int'(loop_pd), 1);
        chk(lol_out == 1'b0 && rdata_out == '1, "R11 R9 idle after abort", int'(lol_out), 0);

        // R11: abort from TRACK, then R12 asynchronous reset from TRACK
        run_entry(22, 0, 4);
        pd_cal_in = 1'b1;
        repeat (3) tick();
        chk(loop_pd == 1'b1 && ready == 1'b0, "R11 abort from track", int'(ready), 0);
        run_entry(22, 0, 4);
        rst_n = 1'b0;
        #1;
        chk(loop_pd == 1'b1 && ready == 1'b0, "R12 reset from track", int'(loop_pd), 1);
        tick();
        rst_n = 1'b1;
        tick();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule